// File: doc/BRIEF.md
# Iterative Early-Out Shift-Add Multiplier

This block multiplies two integers one multiplier bit per clock. A caller presents a multiplicand, a multiplier, an operand size (8, 16 or 32 bits) and a signed/unsigned mode, then pulses `start`. The block returns the double-width product as a high word and a low word. A one-cycle `done` pulse marks the cycle in which both words are valid.

The datapath has three registers. An upper accumulator is one bit wider than the data path. A lower register starts out holding the multiplier, and product bits shift into it from the top. A third register keeps the captured multiplicand. Each loop cycle adds the multiplicand into the accumulator when the multiplier's current low bit is 1, then shifts the accumulator/lower pair right by one. The shift is arithmetic in signed mode and logical in unsigned mode.

The loop stops early once the multiplier bits not yet consumed can no longer change the result. Those bits must be all zero, or, in signed mode, all one. When the multiplier is negative, the multiplicand is then subtracted from the accumulator, at the bit position where the loop stopped. After that, a single barrel shift by the leftover count moves the product to the same place a full-length run would have left it.

The controller has five states:
- `ST_IDLE`: waits for `start`; on start it captures the operands and loads the counter.
- `ST_LOOP`: runs one iteration per cycle.
- `ST_FIX`: applies the signed correction.
- `ST_ALIGN`: performs the realignment shift.
- `ST_DONE`: raises `done` for one cycle.

The transitions are:
- IDLE→LOOP on start.
- LOOP→LOOP while bits remain and the early-out test fails.
- LOOP→FIX when the counter reaches zero or the early-out test passes.
- FIX→ALIGN, ALIGN→DONE and DONE→IDLE, each unconditionally.

Top module: `shiftadd_mult`

## Requirements
- R1: After reset, `done`, `prod_hi` and `prod_lo` are all zero, and the first `start` is accepted.
- R2: In unsigned mode, {`prod_hi`,`prod_lo`} equals the exact 2W-bit product of the low W bits of each operand. W is 8 for `size_sel`=00, 16 for 01 and 32 for 10. Operand bits above W are ignored, and output bits above W in each word are zero.
- R3: In signed mode, the operands' low W bits are read as two's complement, and the two words hold the exact signed 2W-bit product. Each word holds W bits, and its bits above W are zero.
- R4: A `start` raised while an operation is in progress is ignored. The running operation's result and latency are unchanged.
- R5: `done` is high for exactly one cycle per operation.
- R6: Let the start cycle be cycle 0. `done` rises in cycle n+3. Here n is the smallest i in 1..W such that i = W, or multiplier bits W-1..i are all zero, or (signed mode only) all one.
- R7: An unsigned multiplier whose bit W-1 is set runs all W iterations, so `done` appears in cycle W+3.
- R8: A signed multiplier of all ones leaves the loop after one iteration, so `done` appears in cycle 4, with the product equal to minus the multiplicand.
- R9: `size_sel`=11 behaves exactly like 32-bit operation.
- R10: The iteration counter is loaded with W-1 on start and drops by one per loop iteration that does not exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled only when idle) |
| size_sel | input | 2 | Operand width: 00=8, 01=16, 10/11=32 |
| is_signed | input | 1 | 1 = two's complement, 0 = unsigned |
| mcand | input | 32 | Multiplicand (low W bits used) |
| mplier | input | 32 | Multiplier (low W bits used) |
| done | output | 1 | One-cycle result-valid pulse |
| prod_hi | output | 32 | Upper W bits of the product, zero-extended |
| prod_lo | output | 32 | Lower W bits of the product, zero-extended |

## Verification
The bench builds the block with its default 32-bit data path, so the byte, half-word and word sizes are all exercised through the same registers. Because the widest size equals the data path, the accumulator's extra carry bit is reached, by the all-ones unsigned word case. The signed correction is reached at its extreme magnitude, by the most negative multiplicand. The chosen multipliers place the early exit at the first iteration, at mid-range positions and at full length, so the realignment shift is tested at its largest and smallest distances.

// File: rtl/mulit_pkg.sv
package mulit_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOOP  = 3'd1,
        ST_FIX   = 3'd2,
        ST_ALIGN = 3'd3,
        ST_DONE  = 3'd4
    } mul_state_e;

    // operand-size select encodings
    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;

endpackage

// File: rtl/mulit_ctrl.sv
module mulit_ctrl
    import mulit_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] width_m1_i,
    input  logic             early_exit_i,
    output mul_state_e       state_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             done_o
);

    mul_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             last_iter;

    assign last_iter = (cnt_q == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_LOOP;
            ST_LOOP:  if (last_iter || early_exit_i) state_d = ST_FIX;
            ST_FIX:   state_d = ST_ALIGN;
            ST_ALIGN: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and iteration counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                cnt_q <= width_m1_i;
            end else if (state_q == ST_LOOP && !last_iter && !early_exit_i) begin
                cnt_q <= cnt_q - 1'b1;
            end
            // on exit the counter keeps the leftover bit count for ALIGN
        end
    end

    // outputs
    always_comb begin
        state_o = state_q;
        cnt_o   = cnt_q;
        done_o  = (state_q == ST_DONE);
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R5

    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (state_q == ST_IDLE)); // R5

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i) |=> (state_q == ST_LOOP && cnt_q == $past(width_m1_i))); // R10

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOP && !last_iter && !early_exit_i) |=> (state_q == ST_LOOP && cnt_q == $past(cnt_q) - 1'b1)); // R10

    AST_FULL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOP && last_iter) |=> (state_q == ST_FIX)); // R7

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && state_q != ST_DONE) |=> (state_q != ST_IDLE)); // R4

endmodule

// File: rtl/mulit_datapath.sv
module mulit_datapath
    import mulit_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DATA_W),
    localparam int ACC_W = DATA_W + 1,
    localparam int WB    = DATA_W / 4,
    localparam int WH    = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        size_sel_i,
    input  logic              is_signed_i,
    input  logic [DATA_W-1:0] mcand_i,
    input  logic [DATA_W-1:0] mplier_i,
    input  mul_state_e        state_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic              early_exit_o,
    output logic [ACC_W-1:0]  acc_o,
    output logic [DATA_W-1:0] low_o,
    output logic [1:0]        size_o
);

    logic [ACC_W-1:0]  acc_q, mcand_q;
    logic [DATA_W-1:0] low_q;
    logic [1:0]        sz_q;
    logic              sgn_q, neg_q;

    // operand preparation
    logic [ACC_W-1:0]  mc_ext;
    logic [DATA_W-1:0] mp_zext;
    logic              mp_neg;

    always_comb begin
        unique case (size_sel_i)
            SZ_BYTE: begin
                mc_ext  = {{(ACC_W-WB){is_signed_i & mcand_i[WB-1]}}, mcand_i[WB-1:0]};
                mp_zext = {{(DATA_W-WB){1'b0}}, mplier_i[WB-1:0]};
                mp_neg  = is_signed_i & mplier_i[WB-1];
            end
            SZ_HALF: begin
                mc_ext  = {{(ACC_W-WH){is_signed_i & mcand_i[WH-1]}}, mcand_i[WH-1:0]};
                mp_zext = {{(DATA_W-WH){1'b0}}, mplier_i[WH-1:0]};
                mp_neg  = is_signed_i & mplier_i[WH-1];
            end
            default: begin
                mc_ext  = {is_signed_i & mcand_i[DATA_W-1], mcand_i};
                mp_zext = mplier_i;
                mp_neg  = is_signed_i & mplier_i[DATA_W-1];
            end
        endcase
    end

    // one iteration: conditional add then one-bit right shift of the pair
    logic [ACC_W-1:0]        sum;
    logic                    fill;
    logic [ACC_W+DATA_W-1:0] pair_step;
    logic [DATA_W-1:0]       low_next;

    always_comb begin
        sum       = acc_q + (low_q[0] ? mcand_q : '0);
        fill      = sgn_q & sum[ACC_W-1];
        pair_step = {fill, sum, low_q[DATA_W-1:1]};
        low_next  = pair_step[DATA_W-1:0];
    end

    // early-out test on the multiplier bits still unconsumed after this step
    logic [DATA_W-1:0] one_w, rem_mask, rem_bits;
    logic              rem_zero, rem_ones;

    always_comb begin
        one_w        = {{(DATA_W-1){1'b0}}, 1'b1};
        rem_mask     = (one_w << cnt_i) - one_w;
        rem_bits     = low_next & rem_mask;
        rem_zero     = (rem_bits == '0);
        rem_ones     = (rem_bits == rem_mask);
        early_exit_o = (state_i == ST_LOOP) && (rem_zero || (sgn_q && rem_ones));
    end

    // realignment by the leftover count
    logic [ACC_W+DATA_W-1:0] pair_cur, pair_align;

    always_comb begin
        pair_cur = {acc_q, low_q};
        if (sgn_q) pair_align = $signed(pair_cur) >>> cnt_i;
        else       pair_align = pair_cur >> cnt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            low_q   <= '0;
            mcand_q <= '0;
            sz_q    <= SZ_BYTE;
            sgn_q   <= 1'b0;
            neg_q   <= 1'b0;
        end else begin
            unique case (state_i)
                ST_IDLE: begin
                    if (start_i) begin
                        acc_q   <= '0;
                        low_q   <= mp_zext;
                        mcand_q <= mc_ext;
                        sz_q    <= size_sel_i;
                        sgn_q   <= is_signed_i;
                        neg_q   <= mp_neg;
                    end
                end
                ST_LOOP:  {acc_q, low_q} <= pair_step;
                ST_FIX:   if (neg_q) acc_q <= acc_q - mcand_q;
                ST_ALIGN: {acc_q, low_q} <= pair_align;
                default:  ;
            endcase
        end
    end

    assign acc_o  = acc_q;
    assign low_o  = low_q;
    assign size_o = sz_q;

    AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i != ST_IDLE && start_i) |=> ($stable(mcand_q) && $stable(sz_q) && $stable(sgn_q))); // R4

    AST_UNSIGNED_NO_FIX: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_FIX && !sgn_q) |=> $stable(acc_q)); // R2

    AST_ALIGN_STABLE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_ALIGN) |=> $stable(mcand_q)); // R3

endmodule

// File: rtl/mulit_unpack.sv
module mulit_unpack
    import mulit_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int ACC_W = DATA_W + 1,
    localparam int WB    = DATA_W / 4,
    localparam int WH    = DATA_W / 2
) (
    input  logic [ACC_W-1:0]  acc_i,
    input  logic [DATA_W-1:0] low_i,
    input  logic [1:0]        size_i,
    output logic [DATA_W-1:0] hi_o,
    output logic [DATA_W-1:0] lo_o
);

    always_comb begin
        unique case (size_i)
            SZ_BYTE: begin
                hi_o = {{(DATA_W-WB){1'b0}}, acc_i[WB-1:0]};
                lo_o = {{(DATA_W-WB){1'b0}}, low_i[DATA_W-1 -: WB]};
            end
            SZ_HALF: begin
                hi_o = {{(DATA_W-WH){1'b0}}, acc_i[WH-1:0]};
                lo_o = {{(DATA_W-WH){1'b0}}, low_i[DATA_W-1 -: WH]};
            end
            default: begin
                hi_o = acc_i[DATA_W-1:0];
                lo_o = low_i;
            end
        endcase
    end

endmodule

// File: rtl/shiftadd_mult.sv
module shiftadd_mult
    import mulit_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        size_sel,
    input  logic              is_signed,
    input  logic [DATA_W-1:0] mcand,
    input  logic [DATA_W-1:0] mplier,
    output logic              done,
    output logic [DATA_W-1:0] prod_hi,
    output logic [DATA_W-1:0] prod_lo
);

    localparam int CNT_W = $clog2(DATA_W);
    localparam int ACC_W = DATA_W + 1;

    mul_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] width_m1;
    logic             early_exit;
    logic [ACC_W-1:0] acc;
    logic [DATA_W-1:0] low;
    logic [1:0]       size_q;

    always_comb begin
        unique case (size_sel)
            SZ_BYTE: width_m1 = CNT_W'(DATA_W / 4 - 1);
            SZ_HALF: width_m1 = CNT_W'(DATA_W / 2 - 1);
            default: width_m1 = CNT_W'(DATA_W - 1);
        endcase
    end

    mulit_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .width_m1_i   (width_m1),
        .early_exit_i (early_exit),
        .state_o      (state),
        .cnt_o        (cnt),
        .done_o       (done)
    );

    mulit_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .size_sel_i   (size_sel),
        .is_signed_i  (is_signed),
        .mcand_i      (mcand),
        .mplier_i     (mplier),
        .state_i      (state),
        .cnt_i        (cnt),
        .early_exit_o (early_exit),
        .acc_o        (acc),
        .low_o        (low),
        .size_o       (size_q)
    );

    mulit_unpack #(.DATA_W(DATA_W)) u_unpack (
        .acc_i  (acc),
        .low_i  (low),
        .size_i (size_q),
        .hi_o   (prod_hi),
        .lo_o   (prod_lo)
    );

endmodule

// File: tb/tb_shiftadd_mult.sv
module tb_shiftadd_mult;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [1:0]  size_sel;
    logic        is_signed;
    logic [31:0] mcand, mplier;
    logic        done;
    logic [31:0] prod_hi, prod_lo;

    always #5 clk = ~clk;

    shiftadd_mult #(.DATA_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .size_sel(size_sel),
        .is_signed(is_signed), .mcand(mcand), .mplier(mplier),
        .done(done), .prod_hi(prod_hi), .prod_lo(prod_lo)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int wbits(input logic [1:0] s);
        if (s == 2'b00) return 8;
        if (s == 2'b01) return 16;
        return 32;
    endfunction

    function automatic logic [63:0] wmask(input int w);
        return (64'd1 << w) - 64'd1;
    endfunction

    function automatic logic [63:0] ref_prod(input int w, input bit sg,
                                             input logic [31:0] a, input logic [31:0] b);
        logic [63:0] ax, bx, p;
        ax = {32'd0, a} & wmask(w);
        bx = {32'd0, b} & wmask(w);
        if (sg && ax[w-1]) ax = ax | ~wmask(w);
        if (sg && bx[w-1]) bx = bx | ~wmask(w);
        p = ax * bx;
        return p;
    endfunction

    function automatic int niter(input int w, input bit sg, input logic [31:0] b);
        logic [63:0] m, rem, rm;
        m = {32'd0, b} & wmask(w);
        for (int i = 1; i <= w; i++) begin
            if (i == w) return w;
            rem = m >> i;
            rm  = wmask(w - i);
            if ((rem & rm) == 64'd0) return i;
            if (sg && ((rem & rm) == rm)) return i;
        end
        return w;
    endfunction

    task automatic do_mul(input logic [1:0] sz, input bit sg, input logic [31:0] a,
                          input logic [31:0] b, input string req, input bit interfere,
                          output int lat);
        int w;
        logic [63:0] p, ehi, elo;
        w   = wbits(sz);
        p   = ref_prod(w, sg, a, b);
        ehi = (p >> w) & wmask(w);
        elo = p & wmask(w);
        @(negedge clk);
        size_sel = sz; is_signed = sg; mcand = a; mplier = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        if (interfere) begin
            size_sel = 2'b00; is_signed = ~sg; mcand = ~a; mplier = b ^ 32'h5; start = 1'b1;
        end
        while (!done && lat < 100) begin
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        check(lat == niter(w, sg, b) + 3, "R6", "done cycle", 64'(lat), 64'(niter(w, sg, b) + 3));
        check({32'd0, prod_hi} == ehi, req, "prod_hi", {32'd0, prod_hi}, ehi);
        check({32'd0, prod_lo} == elo, req, "prod_lo", {32'd0, prod_lo}, elo);
        @(negedge clk);
        check(done == 1'b0, "R5", "done after pulse", 64'(done), 64'd0);
    endtask

    task automatic t_reset();
        check(done == 1'b0, "R1", "done at reset", 64'(done), 64'd0);
        check(prod_hi == 32'd0, "R1", "prod_hi at reset", 64'(prod_hi), 64'd0);
        check(prod_lo == 32'd0, "R1", "prod_lo at reset", 64'(prod_lo), 64'd0);
    endtask

    task automatic t_unsigned();
        int lat;
        do_mul(2'b00, 1'b0, 32'hDEAD00FF, 32'h123400FF, "R2", 1'b0, lat);
        do_mul(2'b00, 1'b0, 32'h000000C3, 32'h00000005, "R2", 1'b0, lat);
        do_mul(2'b01, 1'b0, 32'h0000ABCD, 32'hFFFF1234, "R2", 1'b0, lat);
        do_mul(2'b10, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, "R2", 1'b0, lat);
        do_mul(2'b10, 1'b0, 32'h89ABCDEF, 32'h00C0FFEE, "R2", 1'b0, lat);
    endtask

    task automatic t_signed();
        int lat;
        do_mul(2'b00, 1'b1, 32'h00000080, 32'h00000080, "R3", 1'b0, lat);
        do_mul(2'b00, 1'b1, 32'h0000007F, 32'h000000F3, "R3", 1'b0, lat);
        do_mul(2'b01, 1'b1, 32'h0000FFFD, 32'h000003E8, "R3", 1'b0, lat);
        do_mul(2'b10, 1'b1, 32'h80000000, 32'h7FFFFFFF, "R3", 1'b0, lat);
        do_mul(2'b10, 1'b1, 32'h80000000, 32'h80000000, "R3", 1'b0, lat);
        do_mul(2'b10, 1'b1, 32'hFFFFFFFB, 32'hFFFFFFF9, "R3", 1'b0, lat);
        do_mul(2'b10, 1'b1, 32'h12345678, 32'hFFFFFF00, "R3", 1'b0, lat);
    endtask

    task automatic t_early_out();
        int lat;
        do_mul(2'b10, 1'b0, 32'h9ABCDEF0, 32'h00000001, "R6", 1'b0, lat);
        check(lat == 4, "R6", "multiplier one exits after one step", 64'(lat), 64'd4);
        do_mul(2'b10, 1'b0, 32'h9ABCDEF0, 32'h00000000, "R6", 1'b0, lat);
        do_mul(2'b10, 1'b0, 32'h00000003, 32'h00010000, "R6", 1'b0, lat);
        check(lat == 20, "R6", "mid-range exit", 64'(lat), 64'd20);
        do_mul(2'b10, 1'b1, 32'h00001234, 32'hFFFFFFFF, "R8", 1'b0, lat);
        check(lat == 4, "R8", "signed all-ones exit", 64'(lat), 64'd4);
        do_mul(2'b00, 1'b1, 32'h00000080, 32'h000000FF, "R8", 1'b0, lat);
        check(lat == 4, "R8", "signed byte all-ones exit", 64'(lat), 64'd4);
    endtask

    task automatic t_full_length();
        int lat;
        do_mul(2'b10, 1'b0, 32'h00000007, 32'h80000000, "R7", 1'b0, lat);
        check(lat == 35, "R7", "word full length (R10 count W-1)", 64'(lat), 64'd35);
        do_mul(2'b01, 1'b0, 32'h0000FFFF, 32'h00008001, "R7", 1'b0, lat);
        check(lat == 19, "R7", "half full length (R10 count W-1)", 64'(lat), 64'd19);
        do_mul(2'b00, 1'b0, 32'h000000AA, 32'h00000080, "R10", 1'b0, lat);
        check(lat == 11, "R10", "byte full length", 64'(lat), 64'd11);
    endtask

    task automatic t_busy_start();
        int lat;
        do_mul(2'b10, 1'b1, 32'hF0F0F0F0, 32'h0F0F0F0F, "R4", 1'b1, lat);
        do_mul(2'b01, 1'b0, 32'h00001111, 32'h00008000, "R4", 1'b1, lat);
        check(lat == 19, "R4", "latency unchanged by busy start", 64'(lat), 64'd19);
    endtask

    task automatic t_size3();
        int lat;
        do_mul(2'b11, 1'b0, 32'hFEDCBA98, 32'h87654321, "R9", 1'b0, lat);
        check(lat == 35, "R9", "size 11 latency", 64'(lat), 64'd35);
        do_mul(2'b11, 1'b1, 32'hFEDCBA98, 32'h07654321, "R9", 1'b0, lat);
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; size_sel = 2'b00; is_signed = 1'b0;
        mcand = '0; mplier = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unsigned();
        t_signed();
        t_early_out();
        t_full_length();
        t_busy_start();
        t_size3();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule